// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block watches for a periodic service request from software and raises a one-clock reset request if that service does not arrive in time. Time is measured in ticks: single-cycle enable pulses from a slow (nominally 1024 Hz) time base, sampled on the fast system clock. A single 16-bit setup word, written through a simple write-enable port, selects the time-out length, an optional closed window, an early-warning offset, standby behaviour and a sticky always-on lock.

In plain mode the timer must be serviced before the time-out length elapses. In window mode each period starts with a closed window during which a service is a fault. An open window of the time-out length follows, and a service there is accepted. An early-warning pulse gives software notice at a programmable tick count into each period. The controller has four states. IDLE means disabled. SHUT is the closed window. OPEN is the open window, or the whole period in plain mode. FIRE is the one-clock reset request. The named transitions are: enable (IDLE to SHUT or OPEN), close-elapsed (SHUT to OPEN), early-kick (SHUT to FIRE), service (OPEN back to the period start), expire (OPEN to FIRE), restart (FIRE to the period start) and disable (any state to IDLE).

Top module: `svc_watchdog`

## Requirements
- R1: After power-on reset every setup field is 0, both outputs are low, and ticks produce no reset request.
- R2: Each length code n (4 bits) selects 8 << n ticks. Codes 12 to 15 behave as code 11 (16384 ticks).
- R3: In plain mode (setup bit 1 = 0) with the timer enabled (setup bit 0 = 1), the tick that completes the time-out length (code in setup bits 7:4) without a service raises rst_req for exactly one clock. A new period then starts from zero.
- R4: A service request (kick) in the open window restarts the period from zero.
- R5: In window mode (setup bit 1 = 1), a kick during the closed window (length code in setup bits 11:8) raises rst_req on the next clock.
- R6: In window mode, a kick after the closed window has elapsed is accepted. Without one, rst_req fires when closed plus open length has elapsed.
- R7: warn is a one-clock pulse on the tick that completes the early-warning offset (code in setup bits 15:12), counted from the start of the period, and occurs at most once per period.
- R8: Writing setup bit 2 = 1 enables the timer regardless of bit 0. Later writes of 0 to bit 2 are ignored until power-on reset.
- R9: When neither bit 0 nor the lock is set the timer is idle: the count is cleared, kicks and ticks are ignored, and re-enabling starts a fresh period.
- R10: While standby is high, ticks are ignored if setup bit 3 is 0 and counted if it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_wdata | input | 16 | Setup word: bit0 enable, bit1 window mode, bit2 lock, bit3 run in standby, 7:4 time-out code, 11:8 closed code, 15:12 warning code |
| tick | input | 1 | One-cycle time-base pulse |
| standby | input | 1 | Standby indication |
| kick | input | 1 | Service request, one cycle |
| rst_req | output | 1 | One-clock reset request |
| warn | output | 1 | One-clock early-warning pulse |

## Verification
The assertions assume that tick, kick and standby are synchronous to clk and that a kick is a single-cycle pulse. They also assume the setup word is not rewritten in the same cycle as a kick, so that the state each property samples is the state the kick acts on. The directed tests drive every input on the falling clock edge, keep kick to one cycle, and leave at least one idle cycle after each setup write. This lets the enable transition settle before ticks are counted.

// File: rtl/svc_wd_pkg.sv
package svc_wd_pkg;

    localparam int CODE_W     = 4;
    localparam int MAX_CODE   = 11;
    localparam int BASE_SHIFT = 3;
    localparam int LEN_W      = BASE_SHIFT + MAX_CODE + 1;
    localparam int AGE_W      = LEN_W + 1;
    localparam int CFG_W      = 4 + 3 * CODE_W;
    localparam int N_SPANS    = 3;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_SHUT,
        WD_OPEN,
        WD_FIRE
    } wd_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] warn_code;
        logic [CODE_W-1:0] shut_code;
        logic [CODE_W-1:0] tmo_code;
        logic              stby_run;
        logic              lock_on;
        logic              win_en;
        logic              run_en;
    } wd_cfg_t;

endpackage

// File: rtl/svc_wd_cfg.sv
module svc_wd_cfg
    import svc_wd_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output wd_cfg_t          cfg,
    output logic             active
);

    wd_cfg_t cfg_q;
    wd_cfg_t wr_fields;

    assign wr_fields = wd_cfg_t'(wr_data);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q         <= wr_fields;
            cfg_q.lock_on <= cfg_q.lock_on | wr_fields.lock_on;
        end
    end

    assign cfg    = cfg_q;
    assign active = cfg_q.run_en | cfg_q.lock_on;

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_q.lock_on |=> cfg_q.lock_on);

endmodule

// File: rtl/svc_wd_span.sv
module svc_wd_span
    import svc_wd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len
);

    logic [CODE_W-1:0] eff_code;

    always_comb begin
        eff_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        len      = LEN_W'(1) << (eff_code + CODE_W'(BASE_SHIFT));
    end

endmodule

// File: rtl/svc_wd_fsm.sv
module svc_wd_fsm
    import svc_wd_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             active,
    input  logic             win_en,
    input  logic             stby_run,
    input  logic [LEN_W-1:0] tmo_len,
    input  logic [LEN_W-1:0] shut_len,
    input  logic [LEN_W-1:0] warn_len,
    input  logic             tick,
    input  logic             standby,
    input  logic             kick,
    output logic             rst_req,
    output logic             warn
);

    wd_state_t        state, state_n;
    logic [AGE_W-1:0] age, age_n, age_inc, end_len;
    logic             warned, warned_n;
    logic             warn_q, warn_n;
    logic             counted;
    wd_state_t        start_st;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state  <= WD_IDLE;
            age    <= '0;
            warned <= 1'b0;
            warn_q <= 1'b0;
        end else begin
            state  <= state_n;
            age    <= age_n;
            warned <= warned_n;
            warn_q <= warn_n;
        end
    end

    always_comb begin
        counted  = tick & (~standby | stby_run);
        age_inc  = age + AGE_W'(1);
        start_st = win_en ? WD_SHUT : WD_OPEN;
        end_len  = win_en ? (AGE_W'(shut_len) + AGE_W'(tmo_len)) : AGE_W'(tmo_len);
        state_n  = state;
        age_n    = age;
        warned_n = warned;
        warn_n   = 1'b0;

        if (!active) begin
            state_n  = WD_IDLE;
            age_n    = '0;
            warned_n = 1'b0;
        end else begin
            unique case (state)
                WD_IDLE: begin
                    state_n  = start_st;
                    age_n    = '0;
                    warned_n = 1'b0;
                end
                WD_SHUT: begin
                    if (kick) begin
                        state_n = WD_FIRE;
                    end else if (counted) begin
                        age_n = age_inc;
                        if (!warned && age_inc >= AGE_W'(warn_len)) begin
                            warn_n   = 1'b1;
                            warned_n = 1'b1;
                        end
                        if (age_inc >= AGE_W'(shut_len)) begin
                            state_n = WD_OPEN;
                        end
                    end
                end
                WD_OPEN: begin
                    if (kick) begin
                        state_n  = start_st;
                        age_n    = '0;
                        warned_n = 1'b0;
                    end else if (counted) begin
                        age_n = age_inc;
                        if (!warned && age_inc >= AGE_W'(warn_len)) begin
                            warn_n   = 1'b1;
                            warned_n = 1'b1;
                        end
                        if (age_inc >= end_len) begin
                            state_n = WD_FIRE;
                        end
                    end
                end
                WD_FIRE: begin
                    state_n  = start_st;
                    age_n    = '0;
                    warned_n = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        rst_req = (state == WD_FIRE);
        warn    = warn_q;
    end

    // R3
    fire_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R7
    warn_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        warn |=> !warn);

    // R5
    early_kick_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == WD_SHUT && kick && active) |=> rst_req);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !active |=> (!rst_req && !warn));

    // R10
    stby_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (active && state == WD_OPEN && !kick && standby && !stby_run) |=> $stable(age));

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_wd_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tick,
    input  logic             standby,
    input  logic             kick,
    output logic             rst_req,
    output logic             warn
);

    wd_cfg_t           cfg;
    logic              active;
    logic [CODE_W-1:0] codes [N_SPANS];
    logic [LEN_W-1:0]  lens  [N_SPANS];

    svc_wd_cfg u_cfg (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg),
        .active  (active)
    );

    assign codes[0] = cfg.tmo_code;
    assign codes[1] = cfg.shut_code;
    assign codes[2] = cfg.warn_code;

    for (genvar g = 0; g < N_SPANS; g++) begin : g_span
        svc_wd_span u_span (
            .code (codes[g]),
            .len  (lens[g])
        );
    end

    svc_wd_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .active   (active),
        .win_en   (cfg.win_en),
        .stby_run (cfg.stby_run),
        .tmo_len  (lens[0]),
        .shut_len (lens[1]),
        .warn_len (lens[2]),
        .tick     (tick),
        .standby  (standby),
        .kick     (kick),
        .rst_req  (rst_req),
        .warn     (warn)
    );

endmodule

// File: tb/test_svc_watchdog.sv
`timescale 1ns/1ps
module test_svc_watchdog;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        tick = 1'b0;
    logic        standby = 1'b0;
    logic        kick = 1'b0;
    logic        rst_req;
    logic        warn;

    int n_tests = 0;
    int n_fail  = 0;
    int n_cyc   = 0;

    always #2.5 clk = ~clk;

    svc_watchdog i_svc_watchdog (
        .clk       (clk),
        .por_n     (por_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tick      (tick),
        .standby   (standby),
        .kick      (kick),
        .rst_req   (rst_req),
        .warn      (warn)
    );

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired: actual %0d cycles expected < 150000", n_cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic [15:0] mk(input bit run, input bit win, input bit lock, input bit stby,
                                 input [3:0] tmo, input [3:0] shut, input [3:0] wrn);
        return {wrn, shut, tmo, stby, lock, win, run};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input bit t, input bit k);
        tick = t;
        kick = k;
        @(negedge clk);
        tick = 1'b0;
        kick = 1'b0;
    endtask

    task automatic wr(input [15:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cyc(0, 0);
    endtask

    task automatic por();
        por_n = 1'b0;
        standby = 1'b0;
        @(negedge clk);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n, output int fires, output int warns);
        fires = 0;
        warns = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1, 0);
            if (rst_req) fires++;
            if (warn) warns++;
        end
    endtask

    task automatic t_reset();
        int f, w;
        por();
        check(rst_req == 0 && warn == 0, "R1 outputs after reset", rst_req, 0);
        ticks(40, f, w);
        check(f == 0, "R1 no fire when reset state", f, 0);
    endtask

    task automatic t_timeout();
        int f, w;
        por();
        wr(mk(1, 0, 0, 0, 4'd0, 4'd0, 4'd15));
        ticks(7, f, w);
        check(f == 0, "R3 no fire before 8 ticks", f, 0);
        cyc(1, 0);
        check(rst_req == 1, "R3 fire at 8th tick", rst_req, 1);
        cyc(0, 0);
        check(rst_req == 0, "R3 fire lasts one clock", rst_req, 0);
        ticks(7, f, w);
        check(f == 0, "R3 new period from zero", f, 0);
        cyc(1, 0);
        check(rst_req == 1, "R3 second period fires", rst_req, 1);
        cyc(0, 0);
    endtask

    task automatic t_codes();
        int f, w;
        por();
        wr(mk(1, 0, 0, 0, 4'd3, 4'd0, 4'd15));
        ticks(63, f, w);
        check(f == 0, "R2 code 3 no early fire", f, 0);
        cyc(1, 0);
        check(rst_req == 1, "R2 code 3 is 64 ticks", rst_req, 1);
        por();
        wr(mk(1, 0, 0, 0, 4'd15, 4'd0, 4'd15));
        ticks(16383, f, w);
        check(f == 0, "R2 code 15 clamps, no early fire", f, 0);
        cyc(1, 0);
        check(rst_req == 1, "R2 code 15 is 16384 ticks", rst_req, 1);
    endtask

    task automatic t_service();
        int f, w;
        por();
        wr(mk(1, 0, 0, 0, 4'd0, 4'd0, 4'd15));
        ticks(6, f, w);
        cyc(0, 1);
        check(rst_req == 0, "R4 kick accepted", rst_req, 0);
        ticks(7, f, w);
        check(f == 0, "R4 period restarted", f, 0);
        cyc(1, 0);
        check(rst_req == 1, "R4 fires 8 ticks after kick", rst_req, 1);
    endtask

    task automatic t_window();
        int f, w;
        por();
        wr(mk(1, 1, 0, 0, 4'd0, 4'd0, 4'd15));
        ticks(3, f, w);
        cyc(0, 1);
        check(rst_req == 1, "R5 kick in closed window", rst_req, 1);
        cyc(0, 0);
        check(rst_req == 0, "R5 single clock", rst_req, 0);
        ticks(8, f, w);
        cyc(0, 1);
        check(rst_req == 0 && f == 0, "R6 kick in open window accepted", rst_req, 0);
        ticks(15, f, w);
        check(f == 0, "R6 no fire before closed+open", f, 0);
        cyc(1, 0);
        check(rst_req == 1, "R6 fire at closed+open", rst_req, 1);
    endtask

    task automatic t_warn();
        int f, w;
        por();
        wr(mk(1, 0, 0, 0, 4'd2, 4'd0, 4'd0));
        ticks(7, f, w);
        check(w == 0, "R7 no early warn", w, 0);
        cyc(1, 0);
        check(warn == 1, "R7 warn at offset", warn, 1);
        cyc(0, 0);
        check(warn == 0, "R7 warn one clock", warn, 0);
        ticks(24, f, w);
        check(w == 0 && f == 1, "R7 once per period", w, 0);
        cyc(0, 0);
        ticks(8, f, w);
        check(w == 1, "R7 warn again next period", w, 1);
    endtask

    task automatic t_lock();
        int f, w;
        por();
        wr(mk(0, 0, 1, 0, 4'd0, 4'd0, 4'd15));
        ticks(8, f, w);
        check(f == 1, "R8 lock enables timer", f, 1);
        cyc(0, 0);
        wr(16'h0000);
        ticks(7, f, w);
        check(f == 0, "R8 period continues", f, 0);
        cyc(1, 0);
        check(rst_req == 1, "R8 clearing lock ignored", rst_req, 1);
    endtask

    task automatic t_disable();
        int f, w;
        por();
        wr(mk(1, 0, 0, 0, 4'd0, 4'd0, 4'd15));
        ticks(5, f, w);
        wr(16'h0000);
        cyc(0, 1);
        check(rst_req == 0, "R9 kick ignored when idle", rst_req, 0);
        ticks(20, f, w);
        check(f == 0, "R9 ticks ignored when idle", f, 0);
        wr(mk(1, 0, 0, 0, 4'd0, 4'd0, 4'd15));
        ticks(7, f, w);
        check(f == 0, "R9 count cleared on disable", f, 0);
        cyc(1, 0);
        check(rst_req == 1, "R9 fresh period fires", rst_req, 1);
    endtask

    task automatic t_standby();
        int f, w;
        por();
        wr(mk(1, 0, 0, 0, 4'd0, 4'd0, 4'd15));
        standby = 1'b1;
        ticks(20, f, w);
        check(f == 0, "R10 halted in standby", f, 0);
        standby = 1'b0;
        ticks(8, f, w);
        check(f == 1, "R10 resumes after standby", f, 1);
        cyc(0, 0);
        wr(mk(1, 0, 0, 1, 4'd0, 4'd0, 4'd15));
        standby = 1'b1;
        ticks(8, f, w);
        check(f == 1, "R10 runs in standby when set", f, 1);
        standby = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_timeout();
        t_codes();
        t_service();
        t_window();
        t_warn();
        t_lock();
        t_disable();
        t_standby();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule